// File: doc/BRIEF.md
# Range Register Update Sequencer

This block changes the memory-type range configuration of a processor core without ever letting the caches or the translation buffers run against a half-written set of range registers. On a start pulse it takes a shared lock and stops cache fills. It flushes the caches, hides global pages if the core supports them, and flushes the TLB. It then parks the default-type register in a disabled, uncacheable state. Next it walks every range register, reading each one and writing it only when the bits that matter differ from the target. Finally it merges the new default type and enable field into the parked copy, restores it, and unwinds the control-register changes in the reverse order.

The target configuration is presented as flat vectors: one base and one mask word per variable range, eleven fixed-range words, a default type byte and a two-bit enable field. The range registers are reached through a request port with valid/ready flow control. The cache-flush and TLB-flush engines, the lock and the control register sit outside the block. Each run ends with a one-cycle done pulse carrying a three-bit mask of the register classes that were rewritten; those bits also collect in a sticky mask.

Top module: `rangecfg_seq`

## Requirements
- R1: After start, the block raises `lock_req` and waits for `lock_gnt`. It then writes the control port with cache-disable 1 and page-global unchanged, and holds `cache_flush_req` until `cache_flush_ack`. If `pge_supported` is 1, it writes the control port with cache-disable 1 and page-global 0. It then holds `tlb_flush_req` until `tlb_flush_ack`.
- R2: After that TLB flush, the default-type register is read and written back with bits 11:10 and 7:0 cleared and all other bits kept. This happens before any range register is touched.
- R3: Variable base register v (address VAR_ADDR+2v) is rewritten with its full target only if the read value differs from the target in low-word bits under 0xFFFFF0FF, or in the lowest HI_BITS bits of the high word.
- R4: Variable mask register v (address VAR_ADDR+2v+1) is rewritten only if the value differs in low-word bits under 0xFFFFF800, or in the lowest HI_BITS bits of the high word.
- R5: The range walk order is base 0, mask 0, base 1, mask 1, and so on. It continues with the fixed registers: one 64 KiB register at FIX64_ADDR, two 16 KiB registers from FIX16_ADDR, and eight 4 KiB registers from FIX4_ADDR. A fixed register is compared over all 64 bits and rewritten only if it differs.
- R6: If the saved default value differs from the target in bits 7:0 (type) or bits 11:10 (enable), the saved copy becomes saved & ~0xCFF | type | enable<<10. Otherwise the saved copy is kept.
- R7: The exit steps run in this order. First, a TLB flush handshake. Second, the saved default value is written back. Third, a control write with cache-disable 0. Fourth, if `pge_supported`, a control write restoring the page-global value seen at lock grant. Fifth, `lock_req` drops.
- R8: `busy` is high from the cycle after start until the done cycle. `done` is a single-cycle pulse in the cycle `lock_req` drops. In that cycle `change_mask` bit 0 = fixed rewritten, bit 1 = variable rewritten, bit 2 = default changed.
- R9: The cycle after each done pulse, `sticky_mask` includes every bit of that run's change mask. Only reset clears it.
- R10: A start pulse while busy is ignored: the run completes with exactly one done pulse and no extra activity.
- R11: `reg_valid`, `reg_we`, `reg_addr` and `reg_wdata` stay stable until `reg_ready`. Read data is taken from `reg_rdata` in the accepting cycle.
- R12: Register, control and flush activity happens only while `lock_req` and `lock_gnt` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| pge_supported | input | 1 | Core has global pages; static during a run |
| tgt_var_base | input | 64*NUM_VAR | Target base words, range v in bits 64v+63:64v |
| tgt_var_mask | input | 64*NUM_VAR | Target mask words, same packing |
| tgt_fix | input | 64*11 | Target fixed-range words in walk order |
| tgt_def_type | input | 8 | Target default type |
| tgt_def_en | input | 2 | Target enable field |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| change_mask | output | 3 | Classes rewritten in this run |
| sticky_mask | output | 3 | Accumulated change classes |
| lock_req | output | 1 | Lock request, held for the whole run |
| lock_gnt | input | 1 | Lock granted |
| ctl_wr | output | 1 | Control register write strobe |
| ctl_cd | output | 1 | Cache-disable value for the write |
| ctl_pge | output | 1 | Page-global-enable value for the write |
| ctl_pge_cur | input | 1 | Current page-global-enable bit |
| cache_flush_req | output | 1 | Write-back-invalidate request |
| cache_flush_ack | input | 1 | Cache flush finished |
| tlb_flush_req | output | 1 | TLB flush request |
| tlb_flush_ack | input | 1 | TLB flush finished |
| reg_valid | output | 1 | Register access valid |
| reg_ready | input | 1 | Register access accepted |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 64 | Write data |
| reg_rdata | input | 64 | Read data, valid when accepted |

## Verification
The bench builds the block with three variable ranges and a high-word field of four implemented bits. This gives a walk of seventeen registers that runs to its final index. It also allows changes confined to high-word bits above bit 35 to be shown as ignored. The register responder stalls one cycle in four, so back-pressure lands on reads and writes of every kind. Runs are made with global-page support both present and absent.

// File: rtl/rangecfg_pkg.sv
package rangecfg_pkg;
  localparam int unsigned REG_W     = 64;
  localparam int unsigned FIX_COUNT = 11;

  localparam logic [REG_W-1:0] DEF_FIELDS   = 64'h0000_0000_0000_0CFF;
  localparam logic [31:0]      BASE_LO_KEEP = 32'hFFFF_F0FF;
  localparam logic [31:0]      MASK_LO_KEEP = 32'hFFFF_F800;

  localparam int unsigned CHG_FIX = 0;
  localparam int unsigned CHG_VAR = 1;
  localparam int unsigned CHG_DEF = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_LOCK, S_CD_SET, S_CFLUSH, S_PGE_CLR, S_TLB_IN, S_DEF_RD, S_DEF_WR,
    S_RNG_RD, S_RNG_WR, S_MERGE, S_TLB_OUT, S_DEF_RST, S_CD_CLR, S_PGE_RST, S_DONE
  } seq_state_e;
endpackage

// File: rtl/rangecfg_tgt_sel.sv
module rangecfg_tgt_sel
  import rangecfg_pkg::*;
#(
  parameter int unsigned NUM_VAR = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned HI_BITS = 4,
  parameter logic [ADDR_W-1:0] VAR_ADDR   = 'h020,
  parameter logic [ADDR_W-1:0] FIX64_ADDR = 'h040,
  parameter logic [ADDR_W-1:0] FIX16_ADDR = 'h048,
  parameter logic [ADDR_W-1:0] FIX4_ADDR  = 'h050,
  localparam int unsigned N_ENT = 2*NUM_VAR + FIX_COUNT,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic [IDX_W-1:0]           idx,
  input  logic [NUM_VAR*REG_W-1:0]   tgt_var_base,
  input  logic [NUM_VAR*REG_W-1:0]   tgt_var_mask,
  input  logic [FIX_COUNT*REG_W-1:0] tgt_fix,
  output logic [ADDR_W-1:0]          sel_addr,
  output logic [REG_W-1:0]           sel_tgt,
  output logic [REG_W-1:0]           sel_keep,
  output logic                       sel_is_fix
);
  localparam logic [31:0] HI_KEEP = 32'((64'd1 << HI_BITS) - 64'd1);

  logic [ADDR_W-1:0] addr_tab [N_ENT];
  logic [REG_W-1:0]  tgt_tab  [N_ENT];
  logic [REG_W-1:0]  keep_tab [N_ENT];

  for (genvar v = 0; v < NUM_VAR; v++) begin : g_var
    assign addr_tab[2*v]   = VAR_ADDR + ADDR_W'(2*v);
    assign tgt_tab[2*v]    = tgt_var_base[v*REG_W +: REG_W];
    assign keep_tab[2*v]   = {HI_KEEP, BASE_LO_KEEP};
    assign addr_tab[2*v+1] = VAR_ADDR + ADDR_W'(2*v+1);
    assign tgt_tab[2*v+1]  = tgt_var_mask[v*REG_W +: REG_W];
    assign keep_tab[2*v+1] = {HI_KEEP, MASK_LO_KEEP};
  end

  for (genvar f = 0; f < FIX_COUNT; f++) begin : g_fix
    if (f == 0) begin : g_64k
      assign addr_tab[2*NUM_VAR+f] = FIX64_ADDR;
    end else if (f < 3) begin : g_16k
      assign addr_tab[2*NUM_VAR+f] = FIX16_ADDR + ADDR_W'(f-1);
    end else begin : g_4k
      assign addr_tab[2*NUM_VAR+f] = FIX4_ADDR + ADDR_W'(f-3);
    end
    assign tgt_tab[2*NUM_VAR+f]  = tgt_fix[f*REG_W +: REG_W];
    assign keep_tab[2*NUM_VAR+f] = '1;
  end

  always_comb begin
    sel_addr   = '0;
    sel_tgt    = '0;
    sel_keep   = '0;
    sel_is_fix = 1'b0;
    if (int'(idx) < N_ENT) begin
      sel_addr   = addr_tab[idx];
      sel_tgt    = tgt_tab[idx];
      sel_keep   = keep_tab[idx];
      sel_is_fix = int'(idx) >= 2*NUM_VAR;
    end
  end
endmodule

// File: rtl/rangecfg_def_merge.sv
module rangecfg_def_merge
  import rangecfg_pkg::*;
(
  input  logic [REG_W-1:0] saved,
  input  logic [7:0]       tgt_type,
  input  logic [1:0]       tgt_en,
  output logic [REG_W-1:0] parked,
  output logic [REG_W-1:0] merged,
  output logic             differs
);
  assign parked  = saved & ~DEF_FIELDS;
  assign merged  = parked | {{(REG_W-12){1'b0}}, tgt_en, 2'b00, tgt_type};
  assign differs = (saved[7:0] != tgt_type) || (saved[11:10] != tgt_en);
endmodule

// File: rtl/rangecfg_seq.sv
module rangecfg_seq
  import rangecfg_pkg::*;
#(
  parameter int unsigned NUM_VAR = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned HI_BITS = 4,
  parameter logic [ADDR_W-1:0] DEF_ADDR   = 'h010,
  parameter logic [ADDR_W-1:0] VAR_ADDR   = 'h020,
  parameter logic [ADDR_W-1:0] FIX64_ADDR = 'h040,
  parameter logic [ADDR_W-1:0] FIX16_ADDR = 'h048,
  parameter logic [ADDR_W-1:0] FIX4_ADDR  = 'h050
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       pge_supported,
  input  logic [NUM_VAR*64-1:0]      tgt_var_base,
  input  logic [NUM_VAR*64-1:0]      tgt_var_mask,
  input  logic [11*64-1:0]           tgt_fix,
  input  logic [7:0]                 tgt_def_type,
  input  logic [1:0]                 tgt_def_en,
  output logic                       busy,
  output logic                       done,
  output logic [2:0]                 change_mask,
  output logic [2:0]                 sticky_mask,
  output logic                       lock_req,
  input  logic                       lock_gnt,
  output logic                       ctl_wr,
  output logic                       ctl_cd,
  output logic                       ctl_pge,
  input  logic                       ctl_pge_cur,
  output logic                       cache_flush_req,
  input  logic                       cache_flush_ack,
  output logic                       tlb_flush_req,
  input  logic                       tlb_flush_ack,
  output logic                       reg_valid,
  input  logic                       reg_ready,
  output logic                       reg_we,
  output logic [ADDR_W-1:0]          reg_addr,
  output logic [63:0]                reg_wdata,
  input  logic [63:0]                reg_rdata
);
  localparam int unsigned N_ENT = 2*NUM_VAR + FIX_COUNT;
  localparam int unsigned IDX_W = $clog2(N_ENT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT-1);

  seq_state_e        state, state_nx;
  logic [IDX_W-1:0]  idx;
  logic [REG_W-1:0]  def_saved;
  logic              pge_q;
  logic [2:0]        cmask;
  logic [2:0]        sticky;

  logic [ADDR_W-1:0] sel_addr;
  logic [REG_W-1:0]  sel_tgt, sel_keep;
  logic              sel_is_fix;
  logic [REG_W-1:0]  def_parked, def_merged;
  logic              def_differs;
  logic              acc, rng_differs, at_last;

  rangecfg_tgt_sel #(
    .NUM_VAR(NUM_VAR), .ADDR_W(ADDR_W), .HI_BITS(HI_BITS), .VAR_ADDR(VAR_ADDR),
    .FIX64_ADDR(FIX64_ADDR), .FIX16_ADDR(FIX16_ADDR), .FIX4_ADDR(FIX4_ADDR)
  ) u_sel (
    .idx(idx), .tgt_var_base(tgt_var_base), .tgt_var_mask(tgt_var_mask), .tgt_fix(tgt_fix),
    .sel_addr(sel_addr), .sel_tgt(sel_tgt), .sel_keep(sel_keep), .sel_is_fix(sel_is_fix)
  );

  rangecfg_def_merge u_merge (
    .saved(def_saved), .tgt_type(tgt_def_type), .tgt_en(tgt_def_en),
    .parked(def_parked), .merged(def_merged), .differs(def_differs)
  );

  assign acc         = reg_valid && reg_ready;
  assign rng_differs = |((reg_rdata ^ sel_tgt) & sel_keep);
  assign at_last     = (idx == LAST_IDX);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:    if (start) state_nx = S_LOCK;
      S_LOCK:    if (lock_gnt) state_nx = S_CD_SET;
      S_CD_SET:  state_nx = S_CFLUSH;
      S_CFLUSH:  if (cache_flush_ack) state_nx = pge_supported ? S_PGE_CLR : S_TLB_IN;
      S_PGE_CLR: state_nx = S_TLB_IN;
      S_TLB_IN:  if (tlb_flush_ack) state_nx = S_DEF_RD;
      S_DEF_RD:  if (acc) state_nx = S_DEF_WR;
      S_DEF_WR:  if (acc) state_nx = S_RNG_RD;
      S_RNG_RD:  if (acc) state_nx = rng_differs ? S_RNG_WR : (at_last ? S_MERGE : S_RNG_RD);
      S_RNG_WR:  if (acc) state_nx = at_last ? S_MERGE : S_RNG_RD;
      S_MERGE:   state_nx = S_TLB_OUT;
      S_TLB_OUT: if (tlb_flush_ack) state_nx = S_DEF_RST;
      S_DEF_RST: if (acc) state_nx = S_CD_CLR;
      S_CD_CLR:  state_nx = pge_supported ? S_PGE_RST : S_DONE;
      S_PGE_RST: state_nx = S_DONE;
      S_DONE:    state_nx = S_IDLE;
      default:   state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      def_saved <= '0;
      pge_q     <= 1'b0;
      cmask     <= '0;
      sticky    <= '0;
    end else begin
      state <= state_nx;
      case (state)
        S_IDLE:   if (start) cmask <= '0;
        S_LOCK:   if (lock_gnt) pge_q <= ctl_pge_cur;
        S_DEF_RD: if (acc) def_saved <= reg_rdata;
        S_DEF_WR: if (acc) idx <= '0;
        S_RNG_RD: if (acc && !rng_differs && !at_last) idx <= idx + 1'b1;
        S_RNG_WR: if (acc) begin
          if (sel_is_fix) cmask[CHG_FIX] <= 1'b1;
          else            cmask[CHG_VAR] <= 1'b1;
          if (!at_last) idx <= idx + 1'b1;
        end
        S_MERGE:  if (def_differs) begin
          def_saved      <= def_merged;
          cmask[CHG_DEF] <= 1'b1;
        end
        S_DONE:   sticky <= sticky | cmask;
        default:  ;
      endcase
    end
  end

  assign busy            = (state != S_IDLE);
  assign done            = (state == S_DONE);
  assign change_mask     = cmask;
  assign sticky_mask     = sticky;
  assign lock_req        = (state != S_IDLE) && (state != S_DONE);
  assign cache_flush_req = (state == S_CFLUSH);
  assign tlb_flush_req   = (state == S_TLB_IN) || (state == S_TLB_OUT);

  always_comb begin
    ctl_wr  = 1'b0;
    ctl_cd  = 1'b0;
    ctl_pge = 1'b0;
    case (state)
      S_CD_SET:  begin ctl_wr = 1'b1; ctl_cd = 1'b1; ctl_pge = pge_q; end
      S_PGE_CLR: begin ctl_wr = 1'b1; ctl_cd = 1'b1; ctl_pge = 1'b0; end
      S_CD_CLR:  begin ctl_wr = 1'b1; ctl_pge = pge_supported ? 1'b0 : pge_q; end
      S_PGE_RST: begin ctl_wr = 1'b1; ctl_pge = pge_q; end
      default:   ;
    endcase
  end

  always_comb begin
    reg_valid = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = DEF_ADDR;
    reg_wdata = '0;
    case (state)
      S_DEF_RD:  reg_valid = 1'b1;
      S_DEF_WR:  begin reg_valid = 1'b1; reg_we = 1'b1; reg_wdata = def_parked; end
      S_RNG_RD:  begin reg_valid = 1'b1; reg_addr = sel_addr; end
      S_RNG_WR:  begin reg_valid = 1'b1; reg_we = 1'b1; reg_addr = sel_addr; reg_wdata = sel_tgt; end
      S_DEF_RST: begin reg_valid = 1'b1; reg_we = 1'b1; reg_wdata = def_saved; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/rangecfg_seq_chk.sv
module rangecfg_seq_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [2:0]        change_mask,
  input logic [2:0]        sticky_mask,
  input logic              lock_req,
  input logic              lock_gnt,
  input logic              ctl_wr,
  input logic              cache_flush_req,
  input logic              cache_flush_ack,
  input logic              tlb_flush_req,
  input logic              tlb_flush_ack,
  input logic              reg_valid,
  input logic              reg_ready,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [63:0]       reg_wdata
);
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)); // R11

  AST_CFLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cache_flush_req && !cache_flush_ack |=> cache_flush_req); // R1

  AST_TLB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_req && !tlb_flush_ack |=> tlb_flush_req); // R7

  AST_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid || ctl_wr || cache_flush_req || tlb_flush_req) |-> lock_req && lock_gnt); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8

  AST_STICKY_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((sticky_mask & $past(change_mask)) == $past(change_mask))); // R9

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !done |=> busy); // R10
endmodule

bind rangecfg_seq rangecfg_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rangecfg_seq_tb.sv
`timescale 1ns/1ps
module rangecfg_seq_tb_top;
  localparam int NV = 3;
  localparam int AW = 12;
  localparam int HB = 4;
  localparam int NE = 2*NV + 11;
  localparam logic [AW-1:0] A_DEF = 12'h010, A_VAR = 12'h020;
  localparam logic [AW-1:0] A_F64 = 12'h040, A_F16 = 12'h048, A_F4 = 12'h050;
  localparam int K_LOCK = 0, K_CTL = 1, K_CFL = 2, K_TLB = 3, K_WR = 4, K_UNLOCK = 5;

  typedef struct { int kind; logic [AW-1:0] addr; logic [63:0] data; string req; } ev_t;
  ev_t exp_q[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, pge_sup = 1'b1;
  logic [NV*64-1:0] tgt_vb, tgt_vm;
  logic [11*64-1:0] tgt_fx;
  logic [7:0] tgt_type;
  logic [1:0] tgt_en;
  logic busy, done, lock_req, ctl_wr, ctl_cd, ctl_pge, cfl_req, tlb_req;
  logic [2:0] change_mask, sticky_mask;
  logic lock_gnt = 1'b0, ctl_pge_cur = 1'b1, cfl_ack = 1'b0, tlb_ack = 1'b0, reg_ready = 1'b0;
  logic reg_valid, reg_we;
  logic [AW-1:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata;

  rangecfg_seq #(.NUM_VAR(NV), .ADDR_W(AW), .HI_BITS(HB), .DEF_ADDR(A_DEF), .VAR_ADDR(A_VAR),
                 .FIX64_ADDR(A_F64), .FIX16_ADDR(A_F16), .FIX4_ADDR(A_F4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pge_supported(pge_sup),
    .tgt_var_base(tgt_vb), .tgt_var_mask(tgt_vm), .tgt_fix(tgt_fx),
    .tgt_def_type(tgt_type), .tgt_def_en(tgt_en), .busy(busy), .done(done),
    .change_mask(change_mask), .sticky_mask(sticky_mask), .lock_req(lock_req), .lock_gnt(lock_gnt),
    .ctl_wr(ctl_wr), .ctl_cd(ctl_cd), .ctl_pge(ctl_pge), .ctl_pge_cur(ctl_pge_cur),
    .cache_flush_req(cfl_req), .cache_flush_ack(cfl_ack), .tlb_flush_req(tlb_req), .tlb_flush_ack(tlb_ack),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  logic [63:0] mem [0:(1<<AW)-1];
  logic model_cd = 1'b0;
  int n_tests = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  logic [2:0] done_mask;
  logic f_reg = 0, f_we = 0, f_ctl = 0, f_cd = 0, f_pge = 0, f_cfl = 0, f_tlb = 0;
  logic [AW-1:0] f_addr;
  logic [63:0] f_wdata;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(input int k);
    if (k < 2*NV) return A_VAR + AW'(k);
    if (k == 2*NV) return A_F64;
    if (k < 2*NV+3) return A_F16 + AW'(k-2*NV-1);
    return A_F4 + AW'(k-2*NV-3);
  endfunction

  function automatic logic [63:0] keep_of(input int k);
    logic [31:0] hi = 32'((64'd1 << HB) - 1);
    if (k >= 2*NV) return '1;
    return (k % 2 == 0) ? {hi, 32'hFFFF_F0FF} : {hi, 32'hFFFF_F800};
  endfunction

  function automatic logic [63:0] tgt_of(input int k);
    if (k >= 2*NV) return tgt_fx[(k-2*NV)*64 +: 64];
    return (k % 2 == 0) ? tgt_vb[(k/2)*64 +: 64] : tgt_vm[(k/2)*64 +: 64];
  endfunction

  task automatic push(input int kind, input logic [AW-1:0] a, input logic [63:0] d, input string req);
    ev_t e;
    e.kind = kind; e.addr = a; e.data = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops the scoreboard as handshakes complete
  task automatic observe(input int kind, input logic [AW-1:0] a, input logic [63:0] d);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R5", 64'(kind), 64'hFF);
      return;
    end
    e = exp_q.pop_front();
    chk(e.kind == kind, e.req, 64'(kind), 64'(e.kind));
    if (e.kind == kind) chk(e.addr == a && e.data == d, e.req, d, e.data);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    if (f_reg && f_we) begin mem[f_addr] = f_wdata; observe(K_WR, f_addr, f_wdata); end
    if (f_ctl) begin model_cd = f_cd; ctl_pge_cur = f_pge; observe(K_CTL, '0, {62'd0, f_cd, f_pge}); end
    if (f_cfl) observe(K_CFL, '0, '0);
    if (f_tlb) observe(K_TLB, '0, '0);
    if (lock_req && !lock_gnt) begin lock_gnt = 1'b1; observe(K_LOCK, '0, '0); end
    else if (!lock_req && lock_gnt) begin lock_gnt = 1'b0; observe(K_UNLOCK, '0, '0); end
    if (done) begin done_cnt++; done_mask = change_mask; end
    reg_ready = reg_valid && (cyc % 4 != 2);
    reg_rdata = mem[reg_addr];
    cfl_ack = cfl_req;
    tlb_ack = tlb_req;
    f_reg = reg_valid && reg_ready; f_we = reg_we; f_addr = reg_addr; f_wdata = reg_wdata;
    f_ctl = ctl_wr; f_cd = ctl_cd; f_pge = ctl_pge;
    f_cfl = cfl_req && cfl_ack; f_tlb = tlb_req && tlb_ack;
  end

  task automatic base_init();
    for (int v = 0; v < NV; v++) begin
      mem[A_VAR + AW'(2*v)]   = {32'h0, 32'h0010_0006 | (32'(v) << 24)};
      mem[A_VAR + AW'(2*v+1)] = {32'h0000_000F, 32'hFFF0_0800};
      tgt_vb[v*64 +: 64] = mem[A_VAR + AW'(2*v)];
      tgt_vm[v*64 +: 64] = mem[A_VAR + AW'(2*v+1)];
    end
    for (int f = 0; f < 11; f++) begin
      mem[addr_of(2*NV+f)] = 64'h0606_0606_0606_0606 ^ 64'(f);
      tgt_fx[f*64 +: 64] = mem[addr_of(2*NV+f)];
    end
    mem[A_DEF] = 64'h8000_0000_0000_1C06;
    tgt_type = 8'h06;
    tgt_en = 2'b11;
  endtask

  task automatic run_case(input bit sup, input bit poke, input logic [2:0] exp_mask, input string tag);
    logic [63:0] def0, fin;
    logic [63:0] tg [NE];
    logic pge0;
    logic [2:0] m;
    int t;
    @(negedge clk);
    pge_sup = sup;
    pge0 = ctl_pge_cur;
    def0 = mem[A_DEF];
    m = 3'b000;
    push(K_LOCK, '0, '0, "R12");
    push(K_CTL, '0, {62'd0, 1'b1, pge0}, "R1");
    push(K_CFL, '0, '0, "R1");
    if (sup) push(K_CTL, '0, {62'd0, 1'b1, 1'b0}, "R1");
    push(K_TLB, '0, '0, "R1");
    push(K_WR, A_DEF, def0 & ~64'hCFF, "R2");
    for (int k = 0; k < NE; k++) begin
      tg[k] = tgt_of(k);
      if (((mem[addr_of(k)] ^ tg[k]) & keep_of(k)) != 0) begin
        push(K_WR, addr_of(k), tg[k], k >= 2*NV ? "R5" : ((k % 2 == 0) ? "R3" : "R4"));
        if (k >= 2*NV) m[0] = 1'b1; else m[1] = 1'b1;
      end
    end
    fin = def0;
    if (def0[7:0] != tgt_type || def0[11:10] != tgt_en) begin
      fin = (def0 & ~64'hCFF) | {52'd0, tgt_en, 2'b00, tgt_type};
      m[2] = 1'b1;
    end
    push(K_TLB, '0, '0, "R7");
    push(K_WR, A_DEF, fin, "R6");
    push(K_CTL, '0, {62'd0, 1'b0, sup ? 1'b0 : pge0}, "R7");
    if (sup) push(K_CTL, '0, {62'd0, 1'b0, pge0}, "R7");
    push(K_UNLOCK, '0, '0, "R7");
    chk(m == exp_mask, {tag, " R8 bench mask"}, 64'(m), 64'(exp_mask));
    done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, "R10 one done per run", 64'(done_cnt), 64'd1);
    chk(done_mask == exp_mask, "R8 change_mask", 64'(done_mask), 64'(exp_mask));
    chk(busy === 1'b0, "R8 idle after done", 64'(busy), 64'd0);
    chk(exp_q.size() == 0, "R7 all steps seen", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    for (int k = 0; k < NE; k++)
      chk(((mem[addr_of(k)] ^ tg[k]) & keep_of(k)) == 0, "R5 final register", mem[addr_of(k)], tg[k]);
    chk(mem[A_DEF] == fin, "R6 final default", mem[A_DEF], fin);
    chk(model_cd == 1'b0 && ctl_pge_cur == pge0, "R7 control restored",
        {62'd0, model_cd, ctl_pge_cur}, {62'd0, 1'b0, pge0});
  endtask

  initial begin
    base_init();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && lock_req === 1'b0 && reg_valid === 1'b0 && ctl_wr === 1'b0,
        "R8 reset outputs", {59'd0, busy, done, lock_req, reg_valid, ctl_wr}, 64'd0);
    chk(sticky_mask === 3'b000, "R9 reset sticky", 64'(sticky_mask), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R7: nothing differs, only the default register is parked and restored
    base_init();
    run_case(1'b1, 1'b0, 3'b000, "R2");

    // R3: ignored low bits 11:8 and high bits above HI_BITS, then a type change
    base_init();
    tgt_vb[0*64 +: 64] = tgt_vb[0*64 +: 64] ^ 64'h0000_0000_0000_0F00;
    tgt_vb[1*64 +: 64] = tgt_vb[1*64 +: 64] ^ 64'h0000_0100_0000_0000;
    tgt_vb[2*64 +: 64] = (tgt_vb[2*64 +: 64] & ~64'hFF) | 64'h01;
    run_case(1'b1, 1'b0, 3'b010, "R3");

    // R4: ignored low bit 3, written for bit 12 and high bit 2
    base_init();
    tgt_vm[0*64 +: 64] = tgt_vm[0*64 +: 64] ^ 64'h8;
    tgt_vm[1*64 +: 64] = tgt_vm[1*64 +: 64] ^ 64'h1000;
    tgt_vm[2*64 +: 64] = tgt_vm[2*64 +: 64] ^ 64'h0000_0004_0000_0000;
    run_case(1'b1, 1'b0, 3'b010, "R4");

    // R5: fixed registers in walk order, first, a 16 KiB one and the last
    base_init();
    tgt_fx[0*64 +: 64] = 64'h0505_0505_0505_0505;
    tgt_fx[2*64 +: 64] = 64'h0000_0000_0000_0001;
    tgt_fx[10*64 +: 64] = 64'h0100_0000_0000_0000;
    run_case(1'b1, 1'b0, 3'b001, "R5");
    @(negedge clk);
    chk(sticky_mask === 3'b011, "R9 sticky after fixed and variable", 64'(sticky_mask), 64'd3);

    // R6: default type and enable change, other bits kept
    base_init();
    tgt_type = 8'h05;
    tgt_en = 2'b10;
    run_case(1'b1, 1'b0, 3'b100, "R6");

    // R1 R7 R10: no global pages, all classes, start poked while busy
    base_init();
    ctl_pge_cur = 1'b0;
    tgt_vb[1*64 +: 64] = tgt_vb[1*64 +: 64] ^ 64'h0000_0000_0010_0000;
    tgt_fx[5*64 +: 64] = 64'h0;
    tgt_en = 2'b01;
    run_case(1'b0, 1'b1, 3'b111, "R1");
    chk(sticky_mask === 3'b111, "R9 sticky full", 64'(sticky_mask), 64'd7);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule